// File: doc/BRIEF.md
# Bad-Block-Skipping Flash Image Loader

This block copies a contiguous image out of raw NAND flash into a destination memory, one page at a time. Software or a boot sequencer gives it a page-aligned flash byte offset, an image length in bytes and a destination base address, then pulses `start`. The loader works out which erase blocks the image covers. Before touching any page of a block, it reads that block's factory bad-block marker. Good blocks are copied page by page. Bad blocks are stepped over, and each one pushes the end of the block window out by one, so the image keeps its full length.

Two helpers do the actual work. A page-read command sequencer is driven through `rdReq`/`rdDone`, and it returns the marker word on `rdMark` when a spare-area read finishes. A data mover is driven through `mvStart`/`mvDone`, and it writes the page just read to `mvDst`. Both are one-cycle request pulses answered by one-cycle completion pulses. The block asserts `done` for one cycle when the copy is complete. It raises `errAlign` for a misaligned offset and `errRange` when the window runs past the end of the device. `badCount` reports the number of blocks skipped.

Geometry is set by parameters (`PAGE_BYTES`, `PAGES_PER_BLK`, `BLOCKS`, `MARK_POS`, `BUS16`). Page and block sizes must be powers of two.

Top module: `bbskip_loader`

## Requirements
- R1: When `start` arrives with an offset that is not a multiple of `PAGE_BYTES`, `errAlign` is high from the next cycle until the next `start`. No `rdReq` is issued, `done` does not pulse and `busy` stays low. A later aligned `start` clears `errAlign`.
- R2: The first block is offset / (PAGE_BYTES·PAGES_PER_BLK). The last block is (offset + size − 1) / (PAGE_BYTES·PAGES_PER_BLK). No request is issued for a block outside the current window.
- R3: The starting page index is (offset mod block size) / PAGE_BYTES. It is used in the first good block only, including when earlier blocks were bad. Every later good block starts at page 0.
- R4: Before any page of a block is read, one request is issued with `rdSpare`=1, `rdPage`=0 and `rdCol`=MARK_POS. In byte mode (BUS16=0) the block is bad when bits 7:0 of `rdMark` differ from 0xFF, and bits 15:8 are ignored.
- R5: A bad block gets no page reads. The last-block limit grows by one and `badCount` increments.
- R6: In a good block, every page from the current page up to page PAGES_PER_BLK−1 is read in ascending order. Each page gets one data read followed by one move.
- R7: The first move targets `dstBase`, and each further move targets an address PAGE_BYTES higher than the one before.
- R8: Once the block counter passes the (possibly extended) last block, `done` is high for exactly one cycle and `busy` then falls. After reset, `busy`, `done`, `rdReq`, `mvStart` and both error flags are low.
- R9: If a block index that is still inside the window reaches `BLOCKS`, the loader stops with `errRange` high and does not pulse `done`. `errRange` clears at the next `start`.
- R10: `rdReq` and `mvStart` are single-cycle pulses. No new request is issued while one is outstanding, and `mvStart` only follows the `rdDone` of that page's data read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (sampled while idle) |
| flashOffs | input | ADDR_W | Flash byte offset of the image |
| imageSize | input | ADDR_W | Image length in bytes (at least 1) |
| dstBase | input | ADDR_W | Destination base address |
| rdReq | output | 1 | Read request pulse to the page sequencer |
| rdSpare | output | 1 | Request targets the spare area (marker check) |
| rdBlock | output | ADDR_W−log2(block bytes) | Block index of the request |
| rdPage | output | log2(PAGES_PER_BLK) | Page index inside the block |
| rdCol | output | 16 | Column: MARK_POS for spare reads, 0 for data |
| rdDone | input | 1 | Read complete pulse |
| rdMark | input | 16 | Marker word, valid with rdDone of a spare read |
| mvStart | output | 1 | Move request pulse to the data mover |
| mvDst | output | ADDR_W | Destination address of this page |
| mvDone | input | 1 | Move complete pulse |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle completion pulse |
| errAlign | output | 1 | Misaligned offset seen at last start |
| errRange | output | 1 | Window ran past the device end |
| badCount | output | ADDR_W−log2(block bytes) | Bad blocks skipped in this load |

## Verification
`errAlign` is due one cycle after the `start` edge, so the bench samples it at the very next falling edge. The other results (the page list, `badCount`, `done`, `errRange`) arrive a variable number of cycles later, depending on the responders' latency. For those, the bench polls at falling edges until a terminal flag appears, and only then compares. A monitor clocked on the rising edge logs every request with the block, page and address presented in that same cycle. It also records how many cycles `done` stays high, so the bench can confirm the pulse lasts exactly one cycle rather than just catching it.

// File: rtl/bbl_pkg.sv
package bbl_pkg;
  typedef struct packed {
    logic load;      // capture window from the start inputs
    logic nextPage;  // a page has been moved: advance page and address
    logic skipBad;   // current block is bad: step over it, widen window
  } bblStrobe_t;

  typedef enum logic [3:0] {
    S_IDLE, S_EVAL, S_CHK_REQ, S_CHK_WAIT,
    S_RD_REQ, S_RD_WAIT, S_MV_REQ, S_MV_WAIT, S_DONE
  } bblState_t;
endpackage

// File: rtl/bbl_dpath.sv
module bbl_dpath import bbl_pkg::*; #(
  parameter int ADDR_W        = 32,
  parameter int PAGE_BYTES    = 512,
  parameter int PAGES_PER_BLK = 4,
  parameter int BLOCKS        = 16,
  parameter bit BUS16         = 1'b0,
  localparam int PAGE_SH = $clog2(PAGE_BYTES),
  localparam int PG_W    = $clog2(PAGES_PER_BLK),
  localparam int BLK_SH  = PAGE_SH + PG_W,
  localparam int BLK_W   = ADDR_W - BLK_SH
) (
  input  logic              clk,
  input  logic              rstN,
  input  bblStrobe_t        strb,
  input  logic [ADDR_W-1:0] flashOffs,
  input  logic [ADDR_W-1:0] imageSize,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [15:0]       markWord,
  output logic [BLK_W-1:0]  curBlock,
  output logic [PG_W-1:0]   curPage,
  output logic [ADDR_W-1:0] curDst,
  output logic [BLK_W-1:0]  badCount,
  output logic              misaligned,
  output logic              pastLast,
  output logic              outOfRange,
  output logic              onLastPage,
  output logic              markBad
);
  localparam logic [PG_W-1:0]   LAST_PG  = PG_W'(PAGES_PER_BLK - 1);
  localparam logic [BLK_W-1:0]  DEV_END  = BLK_W'(BLOCKS);
  localparam logic [ADDR_W-1:0] PG_STEP  = ADDR_W'(PAGE_BYTES);

  logic [BLK_W-1:0]  blkQ, lastQ, badQ;
  logic [PG_W-1:0]   pageQ;
  logic [ADDR_W-1:0] dstQ;
  logic [ADDR_W-1:0] endByte;

  assign endByte = flashOffs + imageSize - ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkQ  <= '0;
      lastQ <= '0;
      badQ  <= '0;
      pageQ <= '0;
      dstQ  <= '0;
    end else if (strb.load) begin
      blkQ  <= flashOffs[ADDR_W-1:BLK_SH];
      lastQ <= endByte[ADDR_W-1:BLK_SH];
      pageQ <= flashOffs[BLK_SH-1:PAGE_SH];
      dstQ  <= dstBase;
      badQ  <= '0;
    end else if (strb.skipBad) begin
      blkQ  <= blkQ + BLK_W'(1);
      lastQ <= lastQ + BLK_W'(1);
      badQ  <= badQ + BLK_W'(1);
    end else if (strb.nextPage) begin
      dstQ <= dstQ + PG_STEP;
      if (pageQ == LAST_PG) begin
        pageQ <= '0;
        blkQ  <= blkQ + BLK_W'(1);
      end else begin
        pageQ <= pageQ + PG_W'(1);
      end
    end
  end

  assign curBlock   = blkQ;
  assign curPage    = pageQ;
  assign curDst     = dstQ;
  assign badCount   = badQ;
  assign misaligned = |flashOffs[PAGE_SH-1:0];
  assign pastLast   = blkQ > lastQ;
  assign outOfRange = blkQ >= DEV_END;
  assign onLastPage = pageQ == LAST_PG;

  generate
    if (BUS16) begin : g_wordMark
      assign markBad = markWord != 16'hFFFF;
    end else begin : g_byteMark
      assign markBad = markWord[7:0] != 8'hFF;
    end
  endgenerate

  // Skipping a bad block moves both ends of the window together.
  p_span_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.skipBad |=> (lastQ - blkQ) == $past(lastQ - blkQ));

  // Moving a page that is not the last one stays in the same block.
  p_page_in_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.nextPage && pageQ != LAST_PG) |=> blkQ == $past(blkQ));
endmodule

// File: rtl/bbl_ctrl.sv
module bbl_ctrl import bbl_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       misaligned,
  input  logic       pastLast,
  input  logic       outOfRange,
  input  logic       onLastPage,
  input  logic       markBad,
  input  logic       rdDone,
  input  logic       mvDone,
  output bblStrobe_t strb,
  output logic       rdReq,
  output logic       rdSpare,
  output logic       mvStart,
  output logic       busy,
  output logic       done,
  output logic       errAlign,
  output logic       errRange
);
  bblState_t st, nxt;

  always_comb begin
    nxt     = st;
    strb    = '0;
    rdReq   = 1'b0;
    rdSpare = 1'b0;
    mvStart = 1'b0;
    done    = 1'b0;
    unique case (st)
      S_IDLE: if (start && !misaligned) begin
        strb.load = 1'b1;
        nxt       = S_EVAL;
      end
      S_EVAL: begin
        if (pastLast)        nxt = S_DONE;
        else if (outOfRange) nxt = S_IDLE;
        else                 nxt = S_CHK_REQ;
      end
      S_CHK_REQ: begin
        rdReq   = 1'b1;
        rdSpare = 1'b1;
        nxt     = S_CHK_WAIT;
      end
      S_CHK_WAIT: if (rdDone) begin
        if (markBad) begin
          strb.skipBad = 1'b1;
          nxt          = S_EVAL;
        end else begin
          nxt = S_RD_REQ;
        end
      end
      S_RD_REQ: begin
        rdReq = 1'b1;
        nxt   = S_RD_WAIT;
      end
      S_RD_WAIT: if (rdDone) nxt = S_MV_REQ;
      S_MV_REQ: begin
        mvStart = 1'b1;
        nxt     = S_MV_WAIT;
      end
      S_MV_WAIT: if (mvDone) begin
        strb.nextPage = 1'b1;
        nxt           = onLastPage ? S_EVAL : S_RD_REQ;
      end
      S_DONE: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= S_IDLE;
      errAlign <= 1'b0;
      errRange <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && start) begin
        errAlign <= misaligned;
        errRange <= 1'b0;
      end else if (st == S_EVAL && !pastLast && outOfRange) begin
        errRange <= 1'b1;
      end
    end
  end

  assign busy = st != S_IDLE;

  p_align_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    errAlign |-> (!busy && !rdReq));

  p_read_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (!pastLast && !outOfRange));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_range_halt_r9: assert property (@(posedge clk) disable iff (!rstN)
    errRange |-> (!busy && !done));

  p_mv_after_rd_r10: assert property (@(posedge clk) disable iff (!rstN)
    mvStart |-> $past(rdDone));
endmodule

// File: rtl/bbskip_loader.sv
module bbskip_loader import bbl_pkg::*; #(
  parameter int ADDR_W        = 32,
  parameter int PAGE_BYTES    = 512,
  parameter int PAGES_PER_BLK = 4,
  parameter int BLOCKS        = 16,
  parameter int MARK_POS      = 5,
  parameter bit BUS16         = 1'b0,
  localparam int PG_W  = $clog2(PAGES_PER_BLK),
  localparam int BLK_W = ADDR_W - $clog2(PAGE_BYTES) - PG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] flashOffs,
  input  logic [ADDR_W-1:0] imageSize,
  input  logic [ADDR_W-1:0] dstBase,
  output logic              rdReq,
  output logic              rdSpare,
  output logic [BLK_W-1:0]  rdBlock,
  output logic [PG_W-1:0]   rdPage,
  output logic [15:0]       rdCol,
  input  logic              rdDone,
  input  logic [15:0]       rdMark,
  output logic              mvStart,
  output logic [ADDR_W-1:0] mvDst,
  input  logic              mvDone,
  output logic              busy,
  output logic              done,
  output logic              errAlign,
  output logic              errRange,
  output logic [BLK_W-1:0]  badCount
);
  bblStrobe_t       strb;
  logic [PG_W-1:0]  curPage;
  logic             misaligned, pastLast, outOfRange, onLastPage, markBad;

  bbl_dpath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLK(PAGES_PER_BLK),
    .BLOCKS(BLOCKS), .BUS16(BUS16)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .flashOffs(flashOffs), .imageSize(imageSize), .dstBase(dstBase),
    .markWord(rdMark),
    .curBlock(rdBlock), .curPage(curPage), .curDst(mvDst),
    .badCount(badCount), .misaligned(misaligned), .pastLast(pastLast),
    .outOfRange(outOfRange), .onLastPage(onLastPage), .markBad(markBad)
  );

  bbl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .misaligned(misaligned), .pastLast(pastLast), .outOfRange(outOfRange),
    .onLastPage(onLastPage), .markBad(markBad),
    .rdDone(rdDone), .mvDone(mvDone),
    .strb(strb), .rdReq(rdReq), .rdSpare(rdSpare), .mvStart(mvStart),
    .busy(busy), .done(done), .errAlign(errAlign), .errRange(errRange)
  );

  assign rdPage = rdSpare ? '0 : curPage;
  assign rdCol  = rdSpare ? 16'(MARK_POS) : 16'h0;
endmodule

// File: tb/bbskip_loader_test.sv
module bbskip_loader_test;
  localparam int MARK = 5;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [31:0] flashOffs = '0, imageSize = '0, dstBase = BASE;
  logic        rdReq, rdSpare, mvStart, busy, done, errAlign, errRange;
  logic [20:0] rdBlock, badCount;
  logic [1:0]  rdPage;
  logic [15:0] rdCol;
  logic [31:0] mvDst;
  logic        rdDone = 1'b0, mvDone = 1'b0;
  logic [15:0] rdMark = '0;

  always #5 clk = ~clk;

  bbskip_loader #(.MARK_POS(MARK)) uut (
    .clk(clk), .rstN(rstN), .start(start), .flashOffs(flashOffs),
    .imageSize(imageSize), .dstBase(dstBase), .rdReq(rdReq), .rdSpare(rdSpare),
    .rdBlock(rdBlock), .rdPage(rdPage), .rdCol(rdCol), .rdDone(rdDone),
    .rdMark(rdMark), .mvStart(mvStart), .mvDst(mvDst), .mvDone(mvDone),
    .busy(busy), .done(done), .errAlign(errAlign), .errRange(errRange),
    .badCount(badCount));

  // Stimulus table: offset, size, bad-block mask (bit n = block n bad).
  localparam logic [79:0] VEC [8] = '{
    {32'd0,     32'd2048, 16'h0000},
    {32'd1024,  32'd3000, 16'h0000},
    {32'd0,     32'd4096, 16'h0001},
    {32'd2560,  32'd512,  16'h0002},
    {32'd28672, 32'd4096, 16'h8000},
    {32'd0,     32'd1024, 16'h0007},
    {32'd100,   32'd512,  16'h0000},
    {32'd1536,  32'd1,    16'h0000}
  };

  logic [15:0] badMask = '0;
  logic        clrLog = 1'b0;
  int rdCnt = 0, mvCnt = 0;
  int nPg = 0, nChk = 0, markViol = 0, protoViol = 0, doneHigh = 0;
  logic dataReady = 1'b0, lastSpare = 1'b0;
  int logBlk [64], logPg [64];
  logic [31:0] logDst [64];

  // Responders and request monitor.
  always @(posedge clk) begin
    rdDone <= 1'b0;
    mvDone <= 1'b0;
    if (rdCnt != 0) begin
      rdCnt <= rdCnt - 1;
      if (rdCnt == 1) begin
        rdDone <= 1'b1;
        if (!lastSpare) dataReady <= 1'b1;
      end
    end
    if (mvCnt != 0) begin
      mvCnt <= mvCnt - 1;
      if (mvCnt == 1) mvDone <= 1'b1;
    end
    if (rdReq) begin
      rdCnt     <= 2;
      lastSpare <= rdSpare;
      rdMark    <= (rdSpare && rdBlock < 21'd16 && badMask[rdBlock[3:0]]) ? 16'h00F0 : 16'h12FF;
    end
    if (mvStart) mvCnt <= 3;
    if (clrLog) begin
      nPg <= 0; nChk <= 0; markViol <= 0; protoViol <= 0; doneHigh <= 0;
      dataReady <= 1'b0;
    end else begin
      if (done) doneHigh <= doneHigh + 1;
      if ((rdReq || mvStart) && (rdCnt != 0 || mvCnt != 0)) protoViol <= protoViol + 1;
      if (rdReq && mvStart) protoViol <= protoViol + 1;
      if (rdReq && rdSpare) begin
        nChk <= nChk + 1;
        if (rdPage != 2'd0 || rdCol != 16'(MARK)) markViol <= markViol + 1;
      end
      if (mvStart) begin
        if (!dataReady) protoViol <= protoViol + 1;
        dataReady <= 1'b0;
        if (nPg < 64) begin
          logBlk[nPg] <= int'(rdBlock);
          logPg[nPg]  <= int'(rdPage);
          logDst[nPg] <= mvDst;
        end
        nPg <= nPg + 1;
      end
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model from the requirements.
  int eN, eChk, eBad;
  bit eRange, eAlign;
  int eBlk [64], ePg [64];

  task automatic model(input int offs, input int size, input logic [15:0] mask);
    int blk, last, pg;
    eN = 0; eChk = 0; eBad = 0; eRange = 0;
    eAlign = (offs % 512) != 0;
    if (eAlign) return;
    blk = offs / 2048; last = (offs + size - 1) / 2048; pg = (offs % 2048) / 512;
    while (blk <= last) begin
      if (blk >= 16) begin eRange = 1; break; end
      eChk++;
      if (mask[blk]) begin
        last++; eBad++;
      end else begin
        for (int p = pg; p < 4; p++) begin
          eBlk[eN] = blk; ePg[eN] = p; eN++;
        end
        pg = 0;
      end
      blk++;
    end
  endtask

  task automatic runOne(input int offs, input int size, input logic [15:0] mask, output bit aligned1);
    @(negedge clk);
    flashOffs = offs; imageSize = size; badMask = mask; clrLog = 1'b1;
    @(negedge clk);
    clrLog = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    aligned1 = errAlign;
    for (int c = 0; c < 5000; c++) begin
      if (!busy && (doneHigh != 0 || errRange || errAlign)) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R8)
    chk(!busy && !done && !rdReq && !mvStart, "R8 reset idle", busy, 0);
    chk(!errAlign && !errRange, "R1 R9 reset flags", errAlign | errRange, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy, "R8 idle after reset", busy, 0);

    foreach (VEC[i]) begin
      bit al1, seqOk, dstOk;
      int offs, size;
      offs = int'(VEC[i][79:48]); size = int'(VEC[i][47:16]);
      model(offs, size, VEC[i][15:0]);
      runOne(offs, size, VEC[i][15:0], al1);
      chk(al1 == eAlign, "R1 errAlign next cycle", al1, eAlign);
      chk(errAlign == eAlign, "R1 errAlign held", errAlign, eAlign);
      chk(nPg == eN, "R6 page count", nPg, eN);
      seqOk = 1; dstOk = 1;
      for (int k = 0; k < eN && k < nPg && k < 64; k++) begin
        if (logBlk[k] != eBlk[k] || logPg[k] != ePg[k]) seqOk = 0;
        if (logDst[k] != BASE + 32'(k * 512)) dstOk = 0;
      end
      chk(seqOk, "R2 R3 block and page order", seqOk, 1);
      chk(dstOk, "R7 destination stepping", dstOk, 1);
      chk(nChk == eChk && markViol == 0, "R4 marker checks", nChk, eChk);
      if (!eAlign) chk(int'(badCount) == eBad, "R5 bad count", badCount, eBad);
      chk(errRange == eRange, "R9 range error", errRange, eRange);
      chk(doneHigh == ((eAlign || eRange) ? 0 : 1), "R8 done pulse width", doneHigh,
          (eAlign || eRange) ? 0 : 1);
      chk(protoViol == 0, "R10 handshake order", protoViol, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end
endmodule